// File: doc/BRIEF.md
# Watermarked Frame Ring Buffer Controller

This block owns the write and read pointers of a circular frame store that lives in external memory. Upstream, a frame pipeline offers the frame as fixed-size bursts, each tagged with start-of-frame and end-of-frame markers. The controller turns each admitted burst into one request on a request/grant memory write port. Downstream, a consumer takes data back out in bursts of the same programmable length.

The fill level is the modular distance between the two pointers, and it is compared with three programmable levels. At the upper level the controller raises a backpressure signal to slow the pipeline. That signal drops only once the level falls under a lower level, which gives hysteresis. At the highest level, the drop level, new frames are refused whole at their first burst, so the store is never overwritten.

Every refused or truncated frame produces a one-cycle event with a cause code. Rising edges of backpressure are counted. Cycles in which a write request waits for its grant are accumulated as a stall measure. An inconsistent threshold setting latches an error flag that only reset clears.

Top module: `frm_ring_ctrl`

## Requirements
- R1: The level output equals written words minus read words. It is never above 2^AW. `mem_addr` and `rd_addr` are the low AW bits of the write and read pointers, and both start at 0.
- R2: `up_slow` goes high one cycle after the level is at or above `cfg_high`. It stays high until the level is below `cfg_low`, and only then drops, also one cycle later.
- R3: `hw_cnt` increases by exactly one for each low-to-high transition of `up_slow`.
- R4: A start-of-frame burst that arrives while the level is at or above `cfg_drop` is refused with cause code 1 and issues no memory request. The later bursts of that frame, up to and including its end-of-frame burst, are discarded with no further event.
- R5: A start-of-frame burst below `cfg_drop` for which free space (2^AW minus level) is smaller than `cfg_len` is refused with cause code 2.
- R6: A mid-frame burst of an admitted frame for which free space is smaller than `cfg_len` truncates the frame with cause code 3. The rest of that frame is discarded with no further event.
- R7: An admitted burst raises `mem_req` with `mem_addr` at the write pointer and `mem_len` = `cfg_len`. The request is held stable, with `up_ready` low, until `mem_gnt`. The write pointer then advances by `cfg_len`.
- R8: `stall_cnt` (32 bits) increases by one for every cycle in which `mem_req` is high and `mem_gnt` is low.
- R9: A `rd_take` pulse advances the read pointer by `cfg_len` only while `rd_ok` is high (level at least `cfg_len`). Otherwise it is ignored and the level and `rd_addr` are unchanged.
- R10: `cfg_err` latches high in the cycle after `cfg_low < cfg_high < cfg_drop <= 2^AW` with 0 < `cfg_len` <= 2^AW is violated. It stays high until reset. While it is set, every start-of-frame burst is refused with cause code 4.
- R11: After synchronous active-low reset, the level, `up_slow`, `hw_cnt`, `stall_cnt`, `mem_req`, `drop_evt` and `cfg_err` are all 0, and `up_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_low | input | AW+1 | Backpressure release level |
| cfg_high | input | AW+1 | Backpressure assert level |
| cfg_drop | input | AW+1 | Frame refusal level |
| cfg_len | input | AW+1 | Burst length in words |
| up_valid | input | 1 | Upstream offers a burst |
| up_sof | input | 1 | Offered burst starts a frame |
| up_eof | input | 1 | Offered burst ends a frame |
| up_ready | output | 1 | Burst accepted this cycle when high with up_valid |
| up_slow | output | 1 | Backpressure to the pipeline |
| mem_req | output | 1 | Memory write burst request |
| mem_addr | output | AW | Burst start word address |
| mem_len | output | AW+1 | Burst length |
| mem_gnt | input | 1 | Memory accepts the burst |
| rd_take | input | 1 | Consumer takes one burst |
| rd_ok | output | 1 | A full burst is available |
| rd_addr | output | AW | Read burst start address |
| lvl | output | AW+1 | Fill level in words |
| drop_evt | output | 1 | One-cycle drop or truncation event |
| drop_code | output | 3 | Cause: 1 over level, 2 no space, 3 truncated, 4 bad setting |
| hw_cnt | output | CW | Backpressure rising-edge count |
| stall_cnt | output | 32 | Grant wait cycles |
| cfg_err | output | 1 | Sticky threshold setting error |

## Verification
The bench fills the store to exactly full. This catches an off-by-one in the free-space test, which would either overrun the read pointer or refuse the final burst that fits. It drains the store across both levels to confirm the hysteresis band. A design that released backpressure at the upper level, or at equality with the lower one, would drop `up_slow` early. It checks that bursts after a refusal or a truncation stay silent until end-of-frame, since a design that kept re-deciding would log repeated events or write partial frames. It also delays grants to confirm the stall count, and pokes reads at an empty store to confirm they are ignored.

// File: rtl/frm_ring_pkg.sv
// Shared types for the frame ring buffer controller.
// Assumes: drop cause values are visible at the top as a 3-bit code.
package frm_ring_pkg;
    typedef enum logic [2:0] {
        DRP_NONE    = 3'd0,
        DRP_OVER    = 3'd1,
        DRP_NOSPACE = 3'd2,
        DRP_TRUNC   = 3'd3,
        DRP_CFG     = 3'd4
    } drop_code_t;

    typedef enum logic {
        ADM_IDLE = 1'b0,
        ADM_WAIT = 1'b1
    } adm_state_t;
endpackage

// File: rtl/rb_ptrs.sv
// Write and read pointers of the circular store, one bit wider than the
// address so that full and empty differ. Assumes callers only advance
// when the level permits.
module rb_ptrs #(
    parameter int AW = 6,
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_adv,
    input  logic          rd_adv,
    input  logic [LW-1:0] len,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [LW-1:0] fill,
    output logic [LW-1:0] free
);
    localparam logic [LW-1:0] DEPTH = LW'(1) << AW;

    logic [LW-1:0] wptr_q, rptr_q;

    // Advance each pointer by one burst when its side completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (wr_adv) wptr_q <= wptr_q + len;
            if (rd_adv) rptr_q <= rptr_q + len;
        end
    end

    // Level is the modular pointer distance; free space is the remainder.
    always_comb begin
        fill    = wptr_q - rptr_q;
        free    = DEPTH - fill;
        wr_addr = wptr_q[AW-1:0];
        rd_addr = rptr_q[AW-1:0];
    end
endmodule

// File: rtl/rb_wmark.sv
// Level monitor: hysteresis backpressure, rising-edge counter and sticky
// check of the threshold setting. Assumes thresholds are quasi-static.
module rb_wmark #(
    parameter int AW = 6,
    parameter int CW = 16,
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] fill,
    input  logic [LW-1:0] lo,
    input  logic [LW-1:0] hi,
    input  logic [LW-1:0] drop_thr,
    input  logic [LW-1:0] len,
    output logic          bp,
    output logic [CW-1:0] hw_cnt,
    output logic          cfg_err
);
    localparam logic [LW-1:0] DEPTH = LW'(1) << AW;

    logic cfg_ok;

    // Ordering and range rules for the programmed levels.
    always_comb begin
        cfg_ok = (lo < hi) && (hi < drop_thr) && (drop_thr <= DEPTH)
              && (len != '0) && (len <= DEPTH);
    end

    // Set at the upper level, clear under the lower one, count rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp     <= 1'b0;
            hw_cnt <= '0;
        end else if (fill >= hi) begin
            bp <= 1'b1;
            if (!bp) hw_cnt <= hw_cnt + 1'b1;
        end else if (fill < lo) begin
            bp <= 1'b0;
        end
    end

    // Latch a bad setting until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_err <= 1'b0;
        else if (!cfg_ok) cfg_err <= 1'b1;
    end
endmodule

// File: rtl/rb_admit.sv
// Frame admission: decides at each burst whether to write, refuse or
// discard, drives the memory request and logs coded drop events.
// Assumes one memory grant completes a whole burst.
module rb_admit
    import frm_ring_pkg::*;
#(
    parameter int AW = 6,
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    input  logic          up_sof,
    input  logic          up_eof,
    input  logic [LW-1:0] fill,
    input  logic [LW-1:0] free,
    input  logic [LW-1:0] drop_thr,
    input  logic [LW-1:0] len,
    input  logic          cfg_err,
    input  logic          mem_gnt,
    output logic          up_ready,
    output logic          mem_req,
    output logic          wr_adv,
    output logic          drop_evt,
    output logic [2:0]    drop_code,
    output logic [31:0]   stall_cnt
);
    adm_state_t st_q;
    drop_code_t code_q, dec_code;
    logic       dropping_q, dec_write, accept;

    // Per-burst admission rule: start bursts check levels, later bursts
    // follow the frame's fate or truncate when space runs out.
    always_comb begin
        accept = up_valid && (st_q == ADM_IDLE);
        if (up_sof) begin
            if (cfg_err)               dec_code = DRP_CFG;
            else if (fill >= drop_thr) dec_code = DRP_OVER;
            else if (free < len)       dec_code = DRP_NOSPACE;
            else                       dec_code = DRP_NONE;
            dec_write = (dec_code == DRP_NONE);
        end else begin
            if (!dropping_q && free < len) dec_code = DRP_TRUNC;
            else                           dec_code = DRP_NONE;
            dec_write = !dropping_q && (free >= len);
        end
    end

    // Request state, frame discard flag, event log and stall counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ADM_IDLE;
            dropping_q <= 1'b0;
            drop_evt   <= 1'b0;
            code_q     <= DRP_NONE;
            stall_cnt  <= '0;
        end else begin
            drop_evt <= 1'b0;
            if (st_q == ADM_WAIT && !mem_gnt) stall_cnt <= stall_cnt + 1'b1;
            case (st_q)
                ADM_IDLE: if (accept) begin
                    if (dec_write) begin
                        st_q       <= ADM_WAIT;
                        dropping_q <= 1'b0;
                    end else begin
                        dropping_q <= !up_eof;
                    end
                    if (dec_code != DRP_NONE) begin
                        drop_evt <= 1'b1;
                        code_q   <= dec_code;
                    end
                end
                ADM_WAIT: if (mem_gnt) st_q <= ADM_IDLE;
                default:  st_q <= ADM_IDLE;
            endcase
        end
    end

    // Port-facing decode of the state.
    always_comb begin
        up_ready  = (st_q == ADM_IDLE);
        mem_req   = (st_q == ADM_WAIT);
        wr_adv    = mem_req && mem_gnt;
        drop_code = code_q;
    end
endmodule

// File: rtl/frm_ring_ctrl.sv
// Top of the watermarked frame ring buffer controller. Connects the
// pointer pair, the level monitor and the admission logic, and serves the
// read side. Assumes the consumer reads in bursts of cfg_len.
module frm_ring_ctrl #(
    parameter int AW = 6,
    parameter int CW = 16,
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cfg_low,
    input  logic [LW-1:0] cfg_high,
    input  logic [LW-1:0] cfg_drop,
    input  logic [LW-1:0] cfg_len,
    input  logic          up_valid,
    input  logic          up_sof,
    input  logic          up_eof,
    output logic          up_ready,
    output logic          up_slow,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [LW-1:0] mem_len,
    input  logic          mem_gnt,
    input  logic          rd_take,
    output logic          rd_ok,
    output logic [AW-1:0] rd_addr,
    output logic [LW-1:0] lvl,
    output logic          drop_evt,
    output logic [2:0]    drop_code,
    output logic [CW-1:0] hw_cnt,
    output logic [31:0]   stall_cnt,
    output logic          cfg_err
);
    logic          wr_adv, rd_adv;
    logic [LW-1:0] fill, free;

    // Read side: a whole burst must be present before it is released.
    always_comb begin
        rd_ok   = (fill >= cfg_len) && (cfg_len != '0);
        rd_adv  = rd_take && rd_ok;
        lvl     = fill;
        mem_len = cfg_len;
    end

    rb_ptrs #(.AW(AW)) ptrs_i (
        .clk(clk), .rst_n(rst_n), .wr_adv(wr_adv), .rd_adv(rd_adv),
        .len(cfg_len), .wr_addr(mem_addr), .rd_addr(rd_addr),
        .fill(fill), .free(free)
    );

    rb_wmark #(.AW(AW), .CW(CW)) wmark_i (
        .clk(clk), .rst_n(rst_n), .fill(fill), .lo(cfg_low), .hi(cfg_high),
        .drop_thr(cfg_drop), .len(cfg_len), .bp(up_slow), .hw_cnt(hw_cnt),
        .cfg_err(cfg_err)
    );

    rb_admit #(.AW(AW)) admit_i (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_sof(up_sof),
        .up_eof(up_eof), .fill(fill), .free(free), .drop_thr(cfg_drop),
        .len(cfg_len), .cfg_err(cfg_err), .mem_gnt(mem_gnt),
        .up_ready(up_ready), .mem_req(mem_req), .wr_adv(wr_adv),
        .drop_evt(drop_evt), .drop_code(drop_code), .stall_cnt(stall_cnt)
    );
endmodule

// File: rtl/frm_ring_chk.sv
// Property checker for frm_ring_ctrl, attached by bind below.
module frm_ring_chk #(
    parameter int AW = 6,
    parameter int CW = 16,
    localparam int LW = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [LW-1:0] cfg_low,
    input logic [LW-1:0] cfg_high,
    input logic          up_slow,
    input logic          up_ready,
    input logic [LW-1:0] lvl,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   stall_cnt,
    input logic [CW-1:0] hw_cnt,
    input logic          cfg_err,
    input logic          drop_evt
);
    localparam logic [LW-1:0] DEPTH = LW'(1) << AW;

    // R1
    lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= DEPTH);

    // R2
    bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_slow && lvl >= cfg_low) |=> up_slow);

    // R2
    bp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_slow && lvl < cfg_high) |=> !up_slow);

    // R3
    hw_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_slow) |-> hw_cnt == CW'($past(hw_cnt) + 1'b1));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R7
    req_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !up_ready);

    // R8
    stall_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> stall_cnt == $past(stall_cnt) + 32'd1);

    // R4
    drop_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |-> !mem_req);

    // R10
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

bind frm_ring_ctrl frm_ring_chk #(.AW(AW), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_low(cfg_low), .cfg_high(cfg_high),
    .up_slow(up_slow), .up_ready(up_ready), .lvl(lvl), .mem_req(mem_req),
    .mem_gnt(mem_gnt), .mem_addr(mem_addr), .stall_cnt(stall_cnt),
    .hw_cnt(hw_cnt), .cfg_err(cfg_err), .drop_evt(drop_evt)
);

// File: tb/frm_ring_ctrl_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, empty reads, grant stalls, no-space and bad settings.
module frm_ring_ctrl_tb_top;
    localparam int AW = 6;
    localparam int CW = 16;
    localparam int LW = AW + 1;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic          rd;
        logic          sof;
        logic          eof;
        logic [LW-1:0] exp_lvl;
        logic [2:0]    exp_code;
        logic          exp_bp;
    } vec_t;

    // rd, sof, eof, level after, cause code (0 = none), backpressure after
    localparam vec_t VEC [23] = '{
        '{1'b0, 1'b1, 1'b0, 7'd8,  3'd0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 7'd16, 3'd0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 7'd24, 3'd0, 1'b0},
        '{1'b0, 1'b0, 1'b1, 7'd32, 3'd0, 1'b1},
        '{1'b0, 1'b1, 1'b1, 7'd40, 3'd0, 1'b1},
        '{1'b0, 1'b1, 1'b0, 7'd48, 3'd0, 1'b1},
        '{1'b0, 1'b0, 1'b0, 7'd56, 3'd0, 1'b1},
        '{1'b0, 1'b0, 1'b0, 7'd64, 3'd0, 1'b1},
        '{1'b0, 1'b0, 1'b0, 7'd64, 3'd3, 1'b1},
        '{1'b0, 1'b0, 1'b1, 7'd64, 3'd0, 1'b1},
        '{1'b0, 1'b1, 1'b0, 7'd64, 3'd1, 1'b1},
        '{1'b0, 1'b0, 1'b0, 7'd64, 3'd0, 1'b1},
        '{1'b0, 1'b0, 1'b1, 7'd64, 3'd0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 7'd56, 3'd0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 7'd48, 3'd0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 7'd40, 3'd0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 7'd32, 3'd0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 7'd24, 3'd0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 7'd16, 3'd0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 7'd8,  3'd0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 7'd16, 3'd0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 7'd24, 3'd0, 1'b0},
        '{1'b0, 1'b0, 1'b1, 7'd32, 3'd0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] cfg_low = 7'd16, cfg_high = 7'd32, cfg_drop = 7'd48, cfg_len = 7'd8;
    logic          up_valid = 1'b0, up_sof = 1'b0, up_eof = 1'b0;
    logic          mem_gnt = 1'b0, rd_take = 1'b0;
    logic          up_ready, up_slow, mem_req, rd_ok, drop_evt, cfg_err;
    logic [AW-1:0] mem_addr, rd_addr;
    logic [LW-1:0] mem_len, lvl;
    logic [2:0]    drop_code;
    logic [CW-1:0] hw_cnt;
    logic [31:0]   stall_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int gnt_wait = 0;
    int cur_lvl = 0;
    logic [AW-1:0] exp_wa = '0, exp_ra = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frm_ring_ctrl #(.AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_low(cfg_low), .cfg_high(cfg_high),
        .cfg_drop(cfg_drop), .cfg_len(cfg_len), .up_valid(up_valid),
        .up_sof(up_sof), .up_eof(up_eof), .up_ready(up_ready),
        .up_slow(up_slow), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_gnt(mem_gnt), .rd_take(rd_take),
        .rd_ok(rd_ok), .rd_addr(rd_addr), .lvl(lvl), .drop_evt(drop_evt),
        .drop_code(drop_code), .hw_cnt(hw_cnt), .stall_cnt(stall_cnt),
        .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cur_lvl = 0;
        exp_wa = '0;
        exp_ra = '0;
    endtask

    // One operation, then one extra clock so backpressure has settled.
    task automatic do_op(input vec_t v);
        if (v.rd) begin
            rd_take = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rd_take = 1'b0;
            if (cur_lvl >= int'(cfg_len)) begin
                exp_ra = exp_ra + AW'(cfg_len);
                cur_lvl = cur_lvl - int'(cfg_len);
            end
            @(negedge clk);
            chk("R9 rd_addr", rd_addr, exp_ra);
        end else begin
            up_valid = 1'b1;
            up_sof = v.sof;
            up_eof = v.eof;
            @(posedge clk);
            @(negedge clk);
            up_valid = 1'b0;
            up_sof = 1'b0;
            up_eof = 1'b0;
            if (v.exp_code == 3'd0) begin
                chk("R7 no drop event", drop_evt, 0);
            end else begin
                chk("R4/R5/R6/R10 drop event", drop_evt, 1);
                case (v.exp_code)
                    3'd1: chk("R4 cause", drop_code, 1);
                    3'd2: chk("R5 cause", drop_code, 2);
                    3'd3: chk("R6 cause", drop_code, 3);
                    default: chk("R10 cause", drop_code, 4);
                endcase
            end
            if (mem_req) begin
                chk("R7 address", mem_addr, exp_wa);
                chk("R7 length", mem_len, cfg_len);
                chk("R7 ready low", up_ready, 0);
                repeat (gnt_wait) @(negedge clk);
                mem_gnt = 1'b1;
                @(negedge clk);
                mem_gnt = 1'b0;
                exp_wa = exp_wa + AW'(cfg_len);
                cur_lvl = cur_lvl + int'(cfg_len);
            end
            @(negedge clk);
        end
        chk("R1 level", lvl, v.exp_lvl);
        chk("R2 backpressure", up_slow, v.exp_bp);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 level", lvl, 0);
        chk("R11 up_slow", up_slow, 0);
        chk("R11 hw_cnt", hw_cnt, 0);
        chk("R11 stall_cnt", stall_cnt, 0);
        chk("R11 mem_req", mem_req, 0);
        chk("R11 drop_evt", drop_evt, 0);
        chk("R11 cfg_err", cfg_err, 0);
        chk("R11 up_ready", up_ready, 1);

        // R9 read on an empty store is ignored
        chk("R9 rd_ok empty", rd_ok, 0);
        do_op('{1'b1, 1'b0, 1'b0, 7'd0, 3'd0, 1'b0});

        // Table walk: fill to full, truncation, refusal, drain, refill
        foreach (VEC[i]) do_op(VEC[i]);
        chk("R3 crossings", hw_cnt, 2);
        chk("R8 no stall", stall_cnt, 0);

        // R8 delayed grant
        do_reset();
        gnt_wait = 3;
        do_op('{1'b0, 1'b1, 1'b1, 7'd8, 3'd0, 1'b0});
        chk("R8 stall cycles", stall_cnt, 3);
        gnt_wait = 0;

        // R5 start burst under the drop level but without room
        cfg_low = 7'd8; cfg_high = 7'd40; cfg_drop = 7'd64; cfg_len = 7'd12;
        do_reset();
        do_op('{1'b0, 1'b1, 1'b0, 7'd12, 3'd0, 1'b0});
        for (int k = 0; k < 4; k++)
            do_op('{1'b0, 1'b0, 1'b0, LW'(24 + 12 * k), 3'd0, (24 + 12 * k) >= 40});
        do_op('{1'b0, 1'b1, 1'b0, 7'd60, 3'd2, 1'b1});
        chk("R5 no config error", cfg_err, 0);

        // R10 bad ordering latches; frames refused until reset
        cfg_low = 7'd16; cfg_high = 7'd32; cfg_drop = 7'd48; cfg_len = 7'd8;
        do_reset();
        cfg_low = 7'd40;
        @(negedge clk);
        cfg_low = 7'd16;
        @(negedge clk);
        chk("R10 sticky", cfg_err, 1);
        do_op('{1'b0, 1'b1, 1'b1, 7'd0, 3'd4, 1'b0});
        chk("R10 still set", cfg_err, 1);
        do_reset();
        chk("R10 cleared by reset", cfg_err, 0);
        do_op('{1'b0, 1'b1, 1'b1, 7'd8, 3'd0, 1'b0});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule